// File: doc/BRIEF.md
# Correlator Frame Header Capture

This block sits on a four-line sample link (sign, magnitude, validity and a frame-start marker) just before a correlator cell. Every frame opens with an in-band header sent serially on the sign line. The header carries the fringe phase rate, the starting phase and the fine (vernier) delay that the cell's phase rotator and delay stage must use. The rest of the frame is sample payload, which the block passes downstream with its validity intact.

The parameters sent in one frame's header are meant for the frame after it. The block therefore keeps two copies. A pending copy is filled as the header bits arrive. An active copy drives the correlator outputs and only changes at a frame-start pulse. The frame-start period is set by whatever produces the marker, and the block works with any frame length. If a frame-start pulse arrives before a header has been fully received, the block discards the partial header, flags an error and keeps the active values.

Top module: `frame_hdr_capture`

## Requirements
- R1: While reset is held, and after it, until a first update: all outputs are zero. This covers the sample outputs, the three parameter outputs, `upd_o` and `err_o`.
- R2: The header is 64 bits long. It is carried on `sgn_i` in the cycle where `bocf_i` is high and in the 63 cycles that follow. The first bit received is bit 63 of the header word. The word is split into three fields: bits 63..32 are the phase rate, bits 31..16 are the initial phase, and bits 15..0 are the vernier delay.
- R3: For every header cycle, the sample outputs one cycle later are all low: `vld_o`, `sgn_o` and `mag_o`. This holds whatever the value of `vld_i`.
- R4: For every cycle outside a header, `sgn_o`, `mag_o` and `vld_o` equal `sgn_i`, `mag_i` and `vld_i` of the previous cycle.
- R5: The parameter outputs change only in the cycle right after a cycle with `bocf_i` high. A header that completes mid-frame has no effect on them.
- R6: Suppose the frame before a `bocf_i` pulse delivered a complete header, meaning at least 64 cycles from its start up to that pulse. Then in the cycle after the pulse, the parameter outputs carry that header's fields, and `upd_o` is high for exactly that one cycle.
- R7: Suppose `bocf_i` arrives while a header is still incomplete. Then in the next cycle `err_o` is high for one cycle, `upd_o` stays low, and the parameter outputs keep their values. The partial header is never applied, including at the frame-start pulse after that.
- R8: A `bocf_i` pulse that follows no complete and no partial header gives neither `upd_o` nor `err_o`. This is the case for the first frame after reset.
- R9: Every `bocf_i` pulse restarts header capture from bit 63. A frame that follows an error frame is captured and applied normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low reset |
| bocf_i | input | 1 | Frame-start marker, one cycle wide |
| sgn_i | input | 1 | Sign line; also carries header bits |
| mag_i | input | 1 | Magnitude line |
| vld_i | input | 1 | Sample validity line |
| sgn_o | output | 1 | Gated sign sample |
| mag_o | output | 1 | Gated magnitude sample |
| vld_o | output | 1 | Gated validity, low during header |
| rate_o | output | 32 | Active phase rate |
| phase_o | output | 16 | Active initial phase |
| delay_o | output | 16 | Active vernier delay |
| upd_o | output | 1 | One-cycle pulse when active parameters change |
| err_o | output | 1 | One-cycle pulse on a truncated header |

## Verification
Every result of this block appears one register after its cause:
- The gated sample outputs of a link cycle are due in the next cycle.
- `upd_o`, `err_o` and the new active parameters are due in the cycle right after the `bocf_i` cycle.

The bench drives the inputs on the falling edge and compares each output at the following falling edge against values it stored from the inputs of the previous cycle. It reads the update and error results at the first falling edge after the frame-start cycle, and confirms one cycle later that the strobe has dropped. The parameter outputs are compared at every later cycle of the frame, so a change in mid-frame is seen in the cycle it happens.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
    localparam int RATE_W  = 32;
    localparam int PHASE_W = 16;
    localparam int DELAY_W = 16;
    localparam int HDR_W   = RATE_W + PHASE_W + DELAY_W;

    typedef struct packed {
        logic [RATE_W-1:0]  rate;
        logic [PHASE_W-1:0] phase;
        logic [DELAY_W-1:0] delay;
    } trk_param_t;
endpackage

// File: rtl/fhc_hdr_shift.sv
module fhc_hdr_shift #(
    parameter int HDR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             bit_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             abort_o,
    output logic [HDR_W-1:0] word_o
);
    localparam int CNT_W = $clog2(HDR_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_W - 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic [HDR_W-1:0] sh;
    } shift_st_t;

    shift_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        busy_o  = sof_i | s_q.act;
        abort_o = sof_i & s_q.act;
        done_o  = 1'b0;
        if (sof_i) begin
            // a frame start always restarts capture with the first (top) bit
            s_d.sh  = {{(HDR_W-1){1'b0}}, bit_i};
            s_d.cnt = CNT_W'(1);
            s_d.act = 1'b1;
        end else if (s_q.act) begin
            s_d.sh  = {s_q.sh[HDR_W-2:0], bit_i};
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == LAST) begin
                done_o  = 1'b1;
                s_d.act = 1'b0;
            end
        end
        word_o = s_d.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fhc_param_bank.sv
module fhc_param_bank import fhc_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             done_i,
    input  logic             abort_i,
    input  logic [HDR_W-1:0] word_i,
    output trk_param_t       act_o,
    output logic             upd_o,
    output logic             err_o
);
    typedef struct packed {
        trk_param_t pend;
        logic       pend_vld;
        trk_param_t act;
        logic       upd;
        logic       err;
    } bank_st_t;

    bank_st_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.upd = 1'b0;
        b_d.err = 1'b0;
        if (done_i) begin
            b_d.pend     = trk_param_t'(word_i);
            b_d.pend_vld = 1'b1;
        end
        if (sof_i) begin
            if (b_q.pend_vld) begin
                b_d.act = b_q.pend;
                b_d.upd = 1'b1;
            end
            b_d.pend_vld = 1'b0;
            b_d.err      = abort_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign act_o = b_q.act;
    assign upd_o = b_q.upd;
    assign err_o = b_q.err;
endmodule

// File: rtl/fhc_payload_gate.sv
module fhc_payload_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hdr_i,
    input  logic sgn_i,
    input  logic mag_i,
    input  logic vld_i,
    output logic sgn_o,
    output logic mag_o,
    output logic vld_o
);
    typedef struct packed {
        logic sgn;
        logic mag;
        logic vld;
    } smp_t;

    smp_t p_d, p_q;

    always_comb begin
        p_d = '{sgn: sgn_i, mag: mag_i, vld: vld_i};
        if (hdr_i) p_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign sgn_o = p_q.sgn;
    assign mag_o = p_q.mag;
    assign vld_o = p_q.vld;
endmodule

// File: rtl/frame_hdr_capture.sv
module frame_hdr_capture import fhc_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bocf_i,
    input  logic               sgn_i,
    input  logic               mag_i,
    input  logic               vld_i,
    output logic               sgn_o,
    output logic               mag_o,
    output logic               vld_o,
    output logic [RATE_W-1:0]  rate_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic [DELAY_W-1:0] delay_o,
    output logic               upd_o,
    output logic               err_o
);
    logic             hdr_busy, hdr_done, hdr_abort;
    logic [HDR_W-1:0] hdr_word;
    trk_param_t       act;

    fhc_hdr_shift #(.HDR_W(HDR_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (bocf_i),
        .bit_i   (sgn_i),
        .busy_o  (hdr_busy),
        .done_o  (hdr_done),
        .abort_o (hdr_abort),
        .word_o  (hdr_word)
    );

    fhc_param_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (bocf_i),
        .done_i  (hdr_done),
        .abort_i (hdr_abort),
        .word_i  (hdr_word),
        .act_o   (act),
        .upd_o   (upd_o),
        .err_o   (err_o)
    );

    fhc_payload_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .hdr_i (hdr_busy),
        .sgn_i (sgn_i),
        .mag_i (mag_i),
        .vld_i (vld_i),
        .sgn_o (sgn_o),
        .mag_o (mag_o),
        .vld_o (vld_o)
    );

    assign rate_o  = act.rate;
    assign phase_o = act.phase;
    assign delay_o = act.delay;
endmodule

// File: rtl/fhc_checker.sv
module fhc_checker import fhc_pkg::*; (
    input logic               clk,
    input logic               rst_n,
    input logic               bocf_i,
    input logic               vld_o,
    input logic               sgn_o,
    input logic               mag_o,
    input logic [RATE_W-1:0]  rate_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic [DELAY_W-1:0] delay_o,
    input logic               upd_o,
    input logic               err_o
);
    // R3
    hdr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bocf_i) |-> (!vld_o && !sgn_o && !mag_o));

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bocf_i) |-> $stable({rate_o, phase_o, delay_o}));

    // R6
    upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(bocf_i));

    // R6
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    // R7
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(bocf_i) && !upd_o));

    // R7
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable({rate_o, phase_o, delay_o}));

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({rate_o, phase_o, delay_o} != '0) |-> (upd_o || $past({rate_o, phase_o, delay_o} != '0)));
endmodule

bind frame_hdr_capture fhc_checker u_fhc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bocf_i  (bocf_i),
    .vld_o   (vld_o),
    .sgn_o   (sgn_o),
    .mag_o   (mag_o),
    .rate_o  (rate_o),
    .phase_o (phase_o),
    .delay_o (delay_o),
    .upd_o   (upd_o),
    .err_o   (err_o)
);

// File: tb/tb_frame_hdr_capture.sv
module tb_frame_hdr_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bocf_i = 1'b0, sgn_i = 1'b0, mag_i = 1'b0, vld_i = 1'b0;
    logic        sgn_o, mag_o, vld_o, upd_o, err_o;
    logic [31:0] rate_o;
    logic [15:0] phase_o, delay_o;

    always #4ns clk = ~clk;

    frame_hdr_capture dut (
        .clk(clk), .rst_n(rst_n), .bocf_i(bocf_i), .sgn_i(sgn_i), .mag_i(mag_i), .vld_i(vld_i),
        .sgn_o(sgn_o), .mag_o(mag_o), .vld_o(vld_o), .rate_o(rate_o), .phase_o(phase_o),
        .delay_o(delay_o), .upd_o(upd_o), .err_o(err_o)
    );

    // {header[63:0], length[15:0], exp_upd, exp_err, exp_active_after_start[63:0]}
    localparam int NFR = 7;
    localparam logic [145:0] FRAMES [NFR] = '{
        {64'h1234_5678_9ABC_DEF0, 16'd80,  1'b0, 1'b0, 64'h0},                    // R8 first frame
        {64'hFEDC_BA98_7654_3210, 16'd64,  1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0},  // R6
        {64'hAAAA_5555_0F0F_F0F0, 16'd40,  1'b1, 1'b0, 64'hFEDC_BA98_7654_3210},  // R6 exact 64
        {64'h0123_4567_89AB_CDEF, 16'd100, 1'b0, 1'b1, 64'hFEDC_BA98_7654_3210},  // R7 truncated
        {64'hCAFE_F00D_1357_2468, 16'd63,  1'b1, 1'b0, 64'h0123_4567_89AB_CDEF},  // R9
        {64'h8000_0001_8001_0001, 16'd70,  1'b0, 1'b1, 64'h0123_4567_89AB_CDEF},  // R7 one short
        {64'h0000_0000_0000_0000, 16'd70,  1'b1, 1'b0, 64'h8000_0001_8001_0001}   // R2 fields
    };

    int tests = 0, fails = 0;
    int hdr_bad = 0, pay_bad = 0, hold_bad = 0;
    logic e_s = 1'b0, e_m = 1'b0, e_v = 1'b0, e_h = 1'b0;
    bit   e_ok = 1'b0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] act_word();
        return {rate_o, phase_o, delay_o};
    endfunction

    task automatic cmp_prev();
        if (e_ok && {sgn_o, mag_o, vld_o} !== {e_s, e_m, e_v}) begin
            if (e_h) hdr_bad++;
            else     pay_bad++;
        end
    endtask

    task automatic run_frame(input int i);
        logic [63:0] hdr, exp_act;
        int len;
        logic s, m, v;
        bit hc;
        hdr = FRAMES[i][145:82];
        len = int'(FRAMES[i][81:66]);
        exp_act = FRAMES[i][63:0];
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            cmp_prev();
            if (c == 1) begin
                chk(upd_o === FRAMES[i][65], "R6 upd at frame start", {63'b0, upd_o}, {63'b0, FRAMES[i][65]});
                chk(err_o === FRAMES[i][64], "R7 err at frame start", {63'b0, err_o}, {63'b0, FRAMES[i][64]});
                chk(act_word() === exp_act, "R2 active fields after start", act_word(), exp_act);
            end
            if (c == 2)
                chk(!upd_o && !err_o, "R6 strobes one cycle", {62'b0, upd_o, err_o}, 64'h0);
            if (c >= 1 && act_word() !== exp_act) hold_bad++;
            hc = (c < 64);
            s = hc ? hdr[63 - c] : lf[0];
            m = lf[1];
            v = hc ? 1'b1 : lf[2];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            bocf_i = (c == 0);
            sgn_i = s; mag_i = m; vld_i = v;
            e_ok = 1'b1; e_h = hc;
            e_s = hc ? 1'b0 : s;
            e_m = hc ? 1'b0 : m;
            e_v = hc ? 1'b0 : v;
        end
        chk(hdr_bad == 0, "R3 header cycles gated", 64'(hdr_bad), 64'h0);
        if (len > 64)
            chk(pay_bad == 0, "R4 payload passthrough", 64'(pay_bad), 64'h0);
        chk(hold_bad == 0, "R5 active held mid-frame", 64'(hold_bad), 64'h0);
        hdr_bad = 0; pay_bad = 0; hold_bad = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({sgn_o, mag_o, vld_o, upd_o, err_o} === 5'b0, "R1 outputs in reset",
            64'({sgn_o, mag_o, vld_o, upd_o, err_o}), 64'h0);
        chk(act_word() === 64'h0, "R1 params in reset", act_word(), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(act_word() === 64'h0 && !upd_o, "R1 idle after reset", act_word(), 64'h0);
        for (int i = 0; i < NFR; i++) run_frame(i);
        @(negedge clk);
        cmp_prev();
        bocf_i = 1'b0; vld_i = 1'b0;
        chk(pay_bad == 0 && hdr_bad == 0, "R4 last payload cycle", 64'(pay_bad + hdr_bad), 64'h0);
        // R7: two adjacent frame starts, the second truncates the first header
        @(negedge clk); bocf_i = 1'b1;
        @(negedge clk); bocf_i = 1'b1;
        @(negedge clk); bocf_i = 1'b0;
        chk(err_o === 1'b1 && !upd_o, "R7 back-to-back starts", {62'b0, err_o, upd_o}, 64'h2);
        chk(act_word() === 64'h0, "R7 active kept", act_word(), 64'h0);
        // R1: reset mid-operation clears the active set
        rst_n = 1'b0;
        @(negedge clk);
        chk(act_word() === 64'h0 && !vld_o, "R1 reset clears", act_word(), 64'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule